// File: doc/BRIEF.md
# Cooling Rotor Tachometer Supervisor

This block watches a set of rotating cooling devices (a group of fans followed by a group of pumps) through their tachometer lines, and it sets the duty of the fan PWM drive from temperature. Each tach line is brought into the clock domain through a two-flop synchronizer. Rising edges are then counted over a shared gate window whose length in clock cycles is programmable. At the end of every window the block publishes each device's edge count and a one-cycle completion strobe. It also publishes a stopped flag for any device that produced no edge, and a wear warning for any device whose count stayed under its expected value for several windows in a row.

The stopped flags drive two supply-permission outputs for the power interlocks. The converter supply is allowed only while every fan turns. The front-end supply is allowed only while the converter supply is allowed and every pump turns. The fan duty is computed every cycle: a floor, plus a gain times the amount by which the hotter of two temperature words exceeds a set point, saturated at full scale. A free-running PWM generator turns that duty into a pin.

Configuration (gate length, per-device expected counts, margin, set point, gain, floor) arrives as input words. Temperature sensor readout is outside the block.

Top module: `tach_supervisor`

## Requirements
- R1: While reset is high, every stopped flag reads 1, every wear flag reads 0, both supply permissions read 0 and the PWM pin reads 0.
- R2: Each device's edge count output gives the number of rising edges seen on its synchronized tach line during the last gate window of `gate_len` cycles. It is updated together with a one-cycle `win_done` pulse.
- R3: A device whose window contained zero rising edges is flagged stopped; a device with at least one edge is not.
- R4: The wear threshold is the device's expected count minus the shared margin, and it is 0 when the margin is not below the expected count. A device's wear flag rises at the end of the third consecutive non-zero window whose count is below that threshold, and not earlier.
- R5: A window at or above the threshold clears the wear flag and the streak. A zero-edge window also clears them, so stopped and wear are never set together.
- R6: The converter supply permission is 1 exactly when no fan (devices 0 to N_FAN-1) is stopped. The front-end supply permission is 1 exactly when the converter permission holds and no pump (the remaining devices) is stopped. Both are registered one cycle after the flags.
- R7: The fan duty equals min_duty + gain x (max(temp_a, temp_b) - setpoint) when the hotter reading exceeds the set point, and min_duty otherwise. It is registered one cycle after its inputs.
- R8: The fan duty saturates at 255 (full scale for the default 8-bit duty) instead of wrapping.
- R9: Over any 255 consecutive cycles of constant duty, the PWM pin is high for exactly `duty` cycles. A duty of 0 keeps it low and a duty of 255 keeps it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tach_i | input | N_DEV | Raw tach lines, fans in the low bits, pumps above |
| gate_len_i | input | GATE_W | Gate window length in cycles (at least 2) |
| nominal_i | input | N_DEV*CNT_W | Expected edges per window, one field per device |
| margin_i | input | CNT_W | Allowed shortfall below expected count |
| temp_a_i | input | TEMP_W | First temperature reading |
| temp_b_i | input | TEMP_W | Second temperature reading |
| setpoint_i | input | TEMP_W | Temperature where proportional boost starts |
| gain_i | input | GAIN_W | Duty steps per temperature step |
| min_duty_i | input | DUTY_W | Duty floor |
| edge_count_o | output | N_DEV*CNT_W | Edge counts of the last window |
| win_done_o | output | 1 | One-cycle pulse when new counts are out |
| stopped_o | output | N_DEV | Zero-edge flag per device |
| wear_o | output | N_DEV | Wear warning per device |
| adc_pwr_ok_o | output | 1 | Converter supply permission |
| afe_pwr_ok_o | output | 1 | Front-end supply permission |
| fan_duty_o | output | DUTY_W | Current fan duty |
| fan_pwm_o | output | 1 | Fan PWM pin |

## Verification
A corrupted edge accumulator or gate counter shows at the next `win_done` pulse, as a count outside one edge of gate length over tach period, or as a stopped flag that disagrees with the stimulus. A wrong wear streak shows within three windows, as a warning that rises one window early or late, or that survives a recovering window. Faults in the permission or duty path reach the ports within two cycles, and a PWM comparator fault shows within one 255-cycle period as a wrong high-time count.

// File: rtl/tach_pkg.sv
`timescale 1ns/1ps
package tach_pkg;
  // consecutive low windows required before a wear warning
  localparam int WEAR_STREAK = 3;
  localparam int STREAK_W    = $clog2(WEAR_STREAK + 1);

  typedef struct packed {
    logic stopped;
    logic wear;
  } rotor_flags_t;
endpackage

// File: rtl/tach_sync_edge.sv
`timescale 1ns/1ps
module tach_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic tach_i,
  output logic rise_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= tach_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/gate_timer.sv
`timescale 1ns/1ps
module gate_timer #(
  parameter int GATE_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GATE_W-1:0] gate_len_i,
  output logic              gate_end_o
);
  logic [GATE_W-1:0] tick_q;
  logic [GATE_W-1:0] last_tick;

  assign last_tick  = gate_len_i - GATE_W'(1);
  assign gate_end_o = (tick_q >= last_tick);

  always_ff @(posedge clk) begin
    if (rst)             tick_q <= '0;
    else if (gate_end_o) tick_q <= '0;
    else                 tick_q <= tick_q + GATE_W'(1);
  end

  // gate window ends are isolated pulses when gate_len >= 2
  assert_gate_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    (gate_end_o && gate_len_i > GATE_W'(1)) |=> !gate_end_o);
endmodule

// File: rtl/tach_channel.sv
`timescale 1ns/1ps
module tach_channel
  import tach_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  input  logic             gate_end_i,
  input  logic [CNT_W-1:0] nominal_i,
  input  logic [CNT_W-1:0] margin_i,
  output logic [CNT_W-1:0] count_o,
  output rotor_flags_t     flags_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]    acc_q;
  logic [CNT_W-1:0]    total;
  logic [CNT_W-1:0]    threshold;
  logic [STREAK_W-1:0] streak_q;
  logic                below;
  logic                empty;

  assign total     = (acc_q == CNT_MAX) ? acc_q : acc_q + CNT_W'(rise_i);
  assign threshold = (nominal_i > margin_i) ? nominal_i - margin_i : '0;
  assign empty     = (total == '0);
  assign below     = (total < threshold);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      count_o  <= '0;
      streak_q <= '0;
      flags_o  <= '{stopped: 1'b1, wear: 1'b0};
    end else if (gate_end_i) begin
      acc_q           <= '0;
      count_o         <= total;
      flags_o.stopped <= empty;
      if (empty || !below) begin
        streak_q     <= '0;
        flags_o.wear <= 1'b0;
      end else begin
        if (streak_q < STREAK_W'(WEAR_STREAK)) streak_q <= streak_q + STREAK_W'(1);
        flags_o.wear <= (streak_q >= STREAK_W'(WEAR_STREAK - 1));
      end
    end else begin
      acc_q <= total;
    end
  end

  assert_wear_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(flags_o.stopped && flags_o.wear));
  assert_wear_on_window_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(flags_o.wear) |-> $past(gate_end_i));
  assert_stopped_on_window_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(flags_o.stopped) |-> $past(gate_end_i));
endmodule

// File: rtl/fan_pwm.sv
`timescale 1ns/1ps
module fan_pwm #(
  parameter int TEMP_W = 12,
  parameter int GAIN_W = 8,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TEMP_W-1:0] temp_a_i,
  input  logic [TEMP_W-1:0] temp_b_i,
  input  logic [TEMP_W-1:0] setpoint_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [DUTY_W-1:0] min_duty_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic              pwm_o
);
  localparam int PROD_W = TEMP_W + GAIN_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic [DUTY_W-1:0] DUTY_MAX = '1;

  logic [TEMP_W-1:0] hot, excess;
  logic [PROD_W-1:0] boost;
  logic [SUM_W-1:0]  raw;
  logic [DUTY_W-1:0] duty_next;
  logic [DUTY_W-1:0] phase_q;

  always_comb begin
    hot       = (temp_a_i >= temp_b_i) ? temp_a_i : temp_b_i;
    excess    = (hot > setpoint_i) ? hot - setpoint_i : '0;
    boost     = PROD_W'(excess) * PROD_W'(gain_i);
    raw       = SUM_W'(boost) + SUM_W'(min_duty_i);
    duty_next = (raw > SUM_W'(DUTY_MAX)) ? DUTY_MAX : raw[DUTY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_o  <= '0;
      phase_q <= '0;
      pwm_o   <= 1'b0;
    end else begin
      duty_o  <= duty_next;
      phase_q <= (phase_q == DUTY_MAX - DUTY_W'(1)) ? '0 : phase_q + DUTY_W'(1);
      pwm_o   <= (phase_q < duty_o);
    end
  end

  assert_duty_floor_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (duty_o >= $past(min_duty_i)));
  assert_pwm_off_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(duty_o) == '0) |-> !pwm_o);
  assert_pwm_full_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(duty_o) == DUTY_MAX) |-> pwm_o);
endmodule

// File: rtl/tach_supervisor.sv
`timescale 1ns/1ps
module tach_supervisor
  import tach_pkg::*;
#(
  parameter int N_FAN  = 2,
  parameter int N_PUMP = 2,
  parameter int CNT_W  = 16,
  parameter int GATE_W = 24,
  parameter int TEMP_W = 12,
  parameter int GAIN_W = 8,
  parameter int DUTY_W = 8,
  localparam int N_DEV = N_FAN + N_PUMP
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_DEV-1:0]       tach_i,
  input  logic [GATE_W-1:0]      gate_len_i,
  input  logic [N_DEV*CNT_W-1:0] nominal_i,
  input  logic [CNT_W-1:0]       margin_i,
  input  logic [TEMP_W-1:0]      temp_a_i,
  input  logic [TEMP_W-1:0]      temp_b_i,
  input  logic [TEMP_W-1:0]      setpoint_i,
  input  logic [GAIN_W-1:0]      gain_i,
  input  logic [DUTY_W-1:0]      min_duty_i,
  output logic [N_DEV*CNT_W-1:0] edge_count_o,
  output logic                   win_done_o,
  output logic [N_DEV-1:0]       stopped_o,
  output logic [N_DEV-1:0]       wear_o,
  output logic                   adc_pwr_ok_o,
  output logic                   afe_pwr_ok_o,
  output logic [DUTY_W-1:0]      fan_duty_o,
  output logic                   fan_pwm_o
);
  logic         gate_end;
  logic [N_DEV-1:0] rise;

  gate_timer #(.GATE_W(GATE_W)) u_gate (
    .clk(clk), .rst(rst), .gate_len_i(gate_len_i), .gate_end_o(gate_end)
  );

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    rotor_flags_t flags;

    tach_sync_edge u_sync (
      .clk(clk), .rst(rst), .tach_i(tach_i[d]), .rise_o(rise[d])
    );

    tach_channel #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst(rst),
      .rise_i(rise[d]),
      .gate_end_i(gate_end),
      .nominal_i(nominal_i[d*CNT_W +: CNT_W]),
      .margin_i(margin_i),
      .count_o(edge_count_o[d*CNT_W +: CNT_W]),
      .flags_o(flags)
    );

    assign stopped_o[d] = flags.stopped;
    assign wear_o[d]    = flags.wear;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_done_o   <= 1'b0;
      adc_pwr_ok_o <= 1'b0;
      afe_pwr_ok_o <= 1'b0;
    end else begin
      win_done_o   <= gate_end;
      adc_pwr_ok_o <= ~|stopped_o[N_FAN-1:0];
      afe_pwr_ok_o <= ~|stopped_o[N_FAN-1:0] & ~|stopped_o[N_DEV-1:N_FAN];
    end
  end

  fan_pwm #(.TEMP_W(TEMP_W), .GAIN_W(GAIN_W), .DUTY_W(DUTY_W)) u_pwm (
    .clk(clk), .rst(rst),
    .temp_a_i(temp_a_i), .temp_b_i(temp_b_i), .setpoint_i(setpoint_i),
    .gain_i(gain_i), .min_duty_i(min_duty_i),
    .duty_o(fan_duty_o), .pwm_o(fan_pwm_o)
  );

  assert_afe_needs_adc_R6: assert property (@(posedge clk) disable iff (rst)
    afe_pwr_ok_o |-> adc_pwr_ok_o);
  assert_adc_follows_fans_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(|stopped_o[N_FAN-1:0])) |-> !adc_pwr_ok_o);
endmodule

// File: tb/tb_tach_supervisor.sv
`timescale 1ns/1ps
module tb_tach_supervisor;
  localparam int N_DEV = 4;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_DEV-1:0] tach = '0;
  logic [23:0] gate_len = 24'd200;
  logic [N_DEV*CNT_W-1:0] nominal;
  logic [CNT_W-1:0] margin = 16'd4;
  logic [11:0] temp_a = 12'd100, temp_b = 12'd100, setpoint = 12'd400;
  logic [7:0] gain = 8'd3, min_duty = 8'd20;
  logic [N_DEV*CNT_W-1:0] edge_count;
  logic win_done, adc_ok, afe_ok, pwm;
  logic [N_DEV-1:0] stopped, wear;
  logic [7:0] duty;

  int checks = 0;
  int fails = 0;
  int period [N_DEV];
  int phase [N_DEV];

  always #2.5 clk = ~clk;

  tach_supervisor dut (
    .clk(clk), .rst(rst), .tach_i(tach), .gate_len_i(gate_len),
    .nominal_i(nominal), .margin_i(margin), .temp_a_i(temp_a), .temp_b_i(temp_b),
    .setpoint_i(setpoint), .gain_i(gain), .min_duty_i(min_duty),
    .edge_count_o(edge_count), .win_done_o(win_done), .stopped_o(stopped),
    .wear_o(wear), .adc_pwr_ok_o(adc_ok), .afe_pwr_ok_o(afe_ok),
    .fan_duty_o(duty), .fan_pwm_o(pwm)
  );

  // tach pattern generator: high for half of each period, 0 period = still
  always @(negedge clk) begin
    for (int i = 0; i < N_DEV; i++) begin
      if (period[i] == 0) begin
        phase[i] = 0;
        tach[i] <= 1'b0;
      end else begin
        phase[i] = (phase[i] + 1) % period[i];
        tach[i] <= (phase[i] < period[i] / 2);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_near(string tag, int act, int exp);
    checks++;
    if (act < exp - 1 || act > exp + 1) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d +/-1", tag, act, exp);
    end
  endtask

  task automatic wait_window();
    @(negedge clk);
    while (win_done !== 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int cnt_of(int d);
    return int'(edge_count[d*CNT_W +: CNT_W]);
  endfunction

  task automatic test_reset();
    repeat (4) @(negedge clk);
    chk("R1 stopped", int'(stopped), 15);
    chk("R1 wear", int'(wear), 0);
    chk("R1 adc_ok", int'(adc_ok), 0);
    chk("R1 afe_ok", int'(afe_ok), 0);
    chk("R1 pwm", int'(pwm), 0);
  endtask

  task automatic test_running();
    for (int i = 0; i < N_DEV; i++) period[i] = 10;
    wait_window();
    wait_window();
    for (int i = 0; i < N_DEV; i++) chk_near("R2 count", cnt_of(i), 20);
    chk("R3 none stopped", int'(stopped), 0);
    chk("R6 adc_ok", int'(adc_ok), 1);
    chk("R6 afe_ok", int'(afe_ok), 1);
    chk("R4 no wear", int'(wear), 0);
  endtask

  task automatic test_wear();
    wait_window();
    period[0] = 20;
    wait_window();
    chk_near("R2 slow count", cnt_of(0), 10);
    chk("R4 wear after 1", int'(wear[0]), 0);
    wait_window();
    chk("R4 wear after 2", int'(wear[0]), 0);
    wait_window();
    chk("R4 wear after 3", int'(wear[0]), 1);
    chk("R4 others clear", int'(wear[3:1]), 0);
    period[0] = 10;
    wait_window();
    wait_window();
    chk("R5 wear cleared", int'(wear[0]), 0);
  endtask

  task automatic test_margin_sat();
    margin = 16'd30;
    period[1] = 20;
    repeat (4) wait_window();
    chk("R4 zero threshold no wear", int'(wear[1]), 0);
    period[1] = 10;
    margin = 16'd4;
    repeat (2) wait_window();
  endtask

  task automatic test_stop();
    period[3] = 0;
    wait_window();
    wait_window();
    chk("R3 pump stopped", int'(stopped[3]), 1);
    chk("R2 zero count", cnt_of(3), 0);
    chk("R6 afe off", int'(afe_ok), 0);
    chk("R6 adc on", int'(adc_ok), 1);
    wait_window();
    wait_window();
    chk("R5 stopped not wear", int'(wear[3]), 0);
    period[0] = 0;
    wait_window();
    wait_window();
    chk("R6 adc off", int'(adc_ok), 0);
    chk("R6 afe off w/ fan", int'(afe_ok), 0);
    period[3] = 10;
    wait_window();
    wait_window();
    chk("R6 afe needs adc", int'(afe_ok), 0);
    period[0] = 10;
    wait_window();
    wait_window();
    chk("R3 restarted", int'(stopped), 0);
    chk("R6 adc back", int'(adc_ok), 1);
    chk("R6 afe back", int'(afe_ok), 1);
  endtask

  task automatic set_temps(int a, int b);
    temp_a = 12'(a);
    temp_b = 12'(b);
    repeat (3) @(negedge clk);
  endtask

  task automatic test_duty();
    set_temps(100, 399);
    chk("R7 below setpoint", int'(duty), 20);
    set_temps(400, 400);
    chk("R7 at setpoint", int'(duty), 20);
    set_temps(410, 430);
    chk("R7 b hotter", int'(duty), 20 + 3 * 30);
    set_temps(450, 420);
    chk("R7 a hotter", int'(duty), 20 + 3 * 50);
    set_temps(500, 300);
    chk("R8 clamp", int'(duty), 255);
  endtask

  task automatic pwm_high(int exp, string tag);
    int hi;
    hi = 0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 255; k++) begin
      @(negedge clk);
      if (pwm) hi++;
    end
    chk(tag, hi, exp);
  endtask

  task automatic test_pwm();
    set_temps(420, 100);
    pwm_high(80, "R9 duty 80");
    set_temps(600, 100);
    pwm_high(255, "R9 duty 255");
    min_duty = 8'd0;
    set_temps(100, 100);
    pwm_high(0, "R9 duty 0");
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < N_DEV; i++) begin
      period[i] = 0;
      phase[i] = 0;
    end
    for (int i = 0; i < N_DEV; i++) nominal[i*CNT_W +: CNT_W] = 16'd20;
    test_reset();
    @(negedge clk);
    rst = 1'b0;
    test_running();
    test_wear();
    test_margin_sat();
    test_stop();
    test_duty();
    test_pwm();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule